// File: doc/BRIEF.md
# Multi-Size Fully Associative Translation Buffer

This block keeps a small set of recently used virtual-to-physical page translations. A lookup presents a virtual address, the user/kernel mode of the access and whether it is a write. One cycle later the block answers with exactly one outcome: a hit with the physical address, a miss, or a permission fault. Any translation may sit in any entry. Each entry maps either an 8 KB base page or a 128 KB superpage. A superpage is sixteen contiguous base pages that share one entry.

On a miss the block raises `miss_pending` and waits. It ignores further lookups until an external agent writes the translation through the fill port, or until the whole buffer is flushed. A fill whose page number and size equal those of a live entry rewrites that entry in place. Otherwise the fill takes the lowest-numbered empty entry, or, when every entry is valid, the least recently used one. The block does not walk page tables and does not decide when to form superpages.

Control is a two-state machine. `ST_READY` accepts lookups. `ST_WAIT_FILL` ignores them. The transitions are:
- `ST_READY`→`ST_WAIT_FILL` on an accepted lookup that misses, when no flush is present in the same cycle.
- `ST_WAIT_FILL`→`ST_READY` on a fill or a flush.
- A flush forces `ST_READY` from either state.

Top module: `mstlb_top`

## Requirements
- R1: After reset, and after any cycle with `flush_all` high, every entry is invalid: `rsp_valid` and `miss_pending` are low after reset, and any later lookup misses until a fill. Flush also returns the machine to `ST_READY`.
- R2: A lookup accepted in `ST_READY` produces `rsp_valid` for one cycle after the next rising edge. In that cycle exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` is high.
- R3: The low 13 address bits are the page offset. For a base-page entry, a hit requires all 19 virtual page bits to match, and `rsp_paddr` = {stored physical page, vaddr[12:0]}.
- R4: For a superpage entry (`fill_super`=1), the match ignores virtual page bits [3:0] (vaddr[16:13]). Those four bits replace the low four bits of the stored physical page in `rsp_paddr`.
- R5: `fill_perm` bit 0 grants user read, bit 1 user write, bit 2 kernel read and bit 3 kernel write. `lk_user`=1 means user mode and `lk_write`=1 means a write. A matching lookup without the needed bit gives `rsp_fault`=1 and `rsp_hit`=0. Whenever `rsp_hit` is low, `rsp_paddr` is zero.
- R6: A miss sets `miss_pending`. While it is set, lookups are ignored (no `rsp_valid`). A fill or a flush clears it. A fault does not set it.
- R7: A fill with the same page number and size as a valid entry overwrites that entry. Later hits return the new physical page.
- R8: A fill goes to the lowest-numbered invalid entry if one exists. Otherwise it replaces the entry least recently filled or hit without fault.
- R9: When `flush_all` and `fill_valid` are high in the same cycle, the flush wins and the fill is dropped.
- R10: A faulting lookup and a miss do not change the recency order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_all | input | 1 | Invalidate every entry |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W (32) | Virtual address to translate |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| lk_write | input | 1 | 1 = write access, 0 = read |
| fill_valid | input | 1 | Write a translation |
| fill_vpn | input | VA_W-13 (19) | Virtual page number of the fill |
| fill_ppn | input | PA_W-13 (19) | Physical page number of the fill |
| fill_super | input | 1 | 1 = 128 KB superpage |
| fill_perm | input | 4 | Permission bits as in R5 |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Permitted translation found |
| rsp_miss | output | 1 | No entry matched |
| rsp_fault | output | 1 | Entry matched, access not permitted |
| rsp_paddr | output | PA_W (32) | Physical address, zero unless hit |
| miss_pending | output | 1 | High while waiting for a fill |

## Verification
Each lookup result appears one register stage after the edge that takes the request. The bench drives a request on a falling edge and reads the outcome on the following falling edge, halfway after that register has loaded. A fill or flush takes effect at the edge after it is driven, so a probe lookup issued at the next falling edge already sees the new contents. `miss_pending` changes on the same edge as the miss result, and the bench reads it together with that result.

// File: rtl/mstlb_pkg.sv
package mstlb_pkg;

    typedef enum logic [0:0] {
        ST_READY     = 1'b0,
        ST_WAIT_FILL = 1'b1
    } tlb_state_e;

    // Permission bits, lowest first: user read, user write, kernel read, kernel write
    typedef struct packed {
        logic kern_wr;
        logic kern_rd;
        logic user_wr;
        logic user_rd;
    } perm_t;

    function automatic logic perm_allows(input perm_t p, input logic user, input logic wr);
        logic ok;
        unique case ({user, wr})
            2'b10:   ok = p.user_rd;
            2'b11:   ok = p.user_wr;
            2'b00:   ok = p.kern_rd;
            default: ok = p.kern_wr;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/mstlb_entries.sv
module mstlb_entries
    import mstlb_pkg::*;
#(
    parameter int N     = 128,
    parameter int VPN_W = 19,
    parameter int PPN_W = 19,
    parameter int SP_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     wr_en,
    input  logic [$clog2(N)-1:0]     wr_idx,
    input  logic [VPN_W-1:0]         wr_vpn,
    input  logic [PPN_W-1:0]         wr_ppn,
    input  logic                     wr_super,
    input  perm_t                    wr_perm,
    input  logic [VPN_W-1:0]         lk_vpn,
    output logic                     lk_hit,
    output logic [$clog2(N)-1:0]     lk_idx,
    output logic [PPN_W-1:0]         lk_ppn,
    output perm_t                    lk_perm,
    output logic                     probe_hit,
    output logic [$clog2(N)-1:0]     probe_idx,
    output logic                     free_any,
    output logic [$clog2(N)-1:0]     free_idx
);
    localparam int IDX_W = $clog2(N);
    localparam logic [VPN_W-1:0] V_SP_MASK = {{(VPN_W-SP_W){1'b1}}, {SP_W{1'b0}}};
    localparam logic [PPN_W-1:0] P_SP_MASK = {{(PPN_W-SP_W){1'b1}}, {SP_W{1'b0}}};

    logic [N-1:0]     valid_q;
    logic [VPN_W-1:0] tag_q  [N];
    logic [PPN_W-1:0] ppn_q  [N];
    logic             sp_q   [N];
    perm_t            perm_q [N];

    logic [N-1:0]     hit_vec;
    logic [N-1:0]     probe_vec;
    logic [VPN_W-1:0] wr_vmask;

    assign wr_vmask = wr_super ? V_SP_MASK : '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !flush) begin
            tag_q[wr_idx]  <= wr_vpn & wr_vmask;
            ppn_q[wr_idx]  <= wr_super ? (wr_ppn & P_SP_MASK) : wr_ppn;
            sp_q[wr_idx]   <= wr_super;
            perm_q[wr_idx] <= wr_perm;
        end
    end

    // Per-entry comparators; the offset width follows each entry's size bit
    for (genvar g = 0; g < N; g++) begin : g_cmp
        logic [VPN_W-1:0] emask;
        assign emask        = sp_q[g] ? V_SP_MASK : '1;
        assign hit_vec[g]   = valid_q[g] && ((lk_vpn & emask) == tag_q[g]);
        assign probe_vec[g] = valid_q[g] && (sp_q[g] == wr_super) &&
                              ((wr_vpn & wr_vmask) == tag_q[g]);
    end

    // Lowest index wins in each encoder
    always_comb begin
        lk_hit    = 1'b0;
        lk_idx    = '0;
        probe_hit = 1'b0;
        probe_idx = '0;
        free_any  = 1'b0;
        free_idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                lk_hit = 1'b1;
                lk_idx = IDX_W'(i);
            end
            if (probe_vec[i]) begin
                probe_hit = 1'b1;
                probe_idx = IDX_W'(i);
            end
            if (!valid_q[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        lk_perm = perm_q[lk_idx];
        if (sp_q[lk_idx]) begin
            lk_ppn = {ppn_q[lk_idx][PPN_W-1:SP_W], lk_vpn[SP_W-1:0]};
        end else begin
            lk_ppn = ppn_q[lk_idx];
        end
    end

    // R1: nothing can match in the cycle after a flush
    a_r1_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit);

    // R7: a fill that names a live page of equal size lands on that entry
    a_r7_overwrite_in_place: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush && probe_hit) |-> (wr_idx == probe_idx));

endmodule

// File: rtl/mstlb_lru.sv
module mstlb_lru #(
    parameter int N = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 touch_en,
    input  logic [$clog2(N)-1:0] touch_idx,
    output logic [$clog2(N)-1:0] oldest_idx
);
    localparam int IDX_W = $clog2(N);
    localparam logic [IDX_W-1:0] AGE_MAX = IDX_W'(N - 1);

    logic [IDX_W-1:0] age_q [N];
    logic [N-1:0]     oldest_vec;

    // Ages form a permutation of 0..N-1; 0 is most recent
    for (genvar g = 0; g < N; g++) begin : g_age
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                age_q[g] <= IDX_W'(g);
            end else if (touch_en) begin
                if (touch_idx == IDX_W'(g)) begin
                    age_q[g] <= '0;
                end else if (age_q[g] < age_q[touch_idx]) begin
                    age_q[g] <= age_q[g] + 1'b1;
                end
            end
        end
        assign oldest_vec[g] = (age_q[g] == AGE_MAX);
    end

    always_comb begin
        oldest_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (oldest_vec[i]) oldest_idx = IDX_W'(i);
        end
    end

    // R8: the recency order always names exactly one oldest entry
    a_r8_single_oldest: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest_vec) == 1);

endmodule

// File: rtl/mstlb_top.sv
module mstlb_top
    import mstlb_pkg::*;
#(
    parameter int N_ENTRIES = 128,
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int OFF_W     = 13,
    parameter int SP_W      = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush_all,
    input  logic                  lk_valid,
    input  logic [VA_W-1:0]       lk_vaddr,
    input  logic                  lk_user,
    input  logic                  lk_write,
    input  logic                  fill_valid,
    input  logic [VA_W-OFF_W-1:0] fill_vpn,
    input  logic [PA_W-OFF_W-1:0] fill_ppn,
    input  logic                  fill_super,
    input  logic [3:0]            fill_perm,
    output logic                  rsp_valid,
    output logic                  rsp_hit,
    output logic                  rsp_miss,
    output logic                  rsp_fault,
    output logic [PA_W-1:0]       rsp_paddr,
    output logic                  miss_pending
);
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;
    localparam int IDX_W = $clog2(N_ENTRIES);

    tlb_state_e       state_q, state_d;

    logic             accept;
    logic             e_hit, e_probe_hit, e_free_any;
    logic [IDX_W-1:0] e_idx, e_probe_idx, e_free_idx, lru_oldest;
    logic [IDX_W-1:0] fill_target, touch_idx;
    logic             touch_en, allowed;
    logic [PPN_W-1:0] e_ppn;
    perm_t            e_perm;

    assign accept  = lk_valid && (state_q == ST_READY);
    assign allowed = perm_allows(e_perm, lk_user, lk_write);

    // Rewrite in place, else take a free slot, else evict the oldest
    assign fill_target = e_probe_hit ? e_probe_idx :
                         (e_free_any ? e_free_idx : lru_oldest);

    always_comb begin
        touch_en  = 1'b0;
        touch_idx = e_idx;
        if (flush_all) begin
            touch_en = 1'b0;
        end else if (fill_valid) begin
            touch_en  = 1'b1;
            touch_idx = fill_target;
        end else if (accept && e_hit && allowed) begin
            touch_en = 1'b1;
        end
    end

    mstlb_entries #(
        .N(N_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .SP_W(SP_W)
    ) u_entries (
        .clk(clk), .rst_n(rst_n), .flush(flush_all),
        .wr_en(fill_valid), .wr_idx(fill_target), .wr_vpn(fill_vpn),
        .wr_ppn(fill_ppn), .wr_super(fill_super), .wr_perm(perm_t'(fill_perm)),
        .lk_vpn(lk_vaddr[VA_W-1:OFF_W]),
        .lk_hit(e_hit), .lk_idx(e_idx), .lk_ppn(e_ppn), .lk_perm(e_perm),
        .probe_hit(e_probe_hit), .probe_idx(e_probe_idx),
        .free_any(e_free_any), .free_idx(e_free_idx)
    );

    mstlb_lru #(.N(N_ENTRIES)) u_lru (
        .clk(clk), .rst_n(rst_n),
        .touch_en(touch_en), .touch_idx(touch_idx),
        .oldest_idx(lru_oldest)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: begin
                if (!flush_all && accept && !e_hit) state_d = ST_WAIT_FILL;
            end
            ST_WAIT_FILL: begin
                if (flush_all || fill_valid) state_d = ST_READY;
            end
            default: state_d = ST_READY;
        endcase
    end

    assign miss_pending = (state_q == ST_WAIT_FILL);

    // Registered lookup response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= accept;
            rsp_hit   <= accept && e_hit && allowed;
            rsp_miss  <= accept && !e_hit;
            rsp_fault <= accept && e_hit && !allowed;
            rsp_paddr <= (accept && e_hit && allowed) ?
                         {e_ppn, lk_vaddr[OFF_W-1:0]} : '0;
        end
    end

    // R2: one outcome per answer
    a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1));

    // R2: an answer only follows a request taken in the ready state
    a_r2_answer_follows_request: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(lk_valid) && ($past(state_q) == ST_READY)));

    // R6: no answers while waiting for a fill
    a_r6_wait_blocks_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        miss_pending |=> !rsp_valid);

    // R6: a reported miss leaves the block waiting unless a flush came with it
    a_r6_miss_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_miss && !$past(flush_all)) |-> miss_pending);

    // R5: no address leaves on a fault or a miss
    a_r5_no_addr_unless_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_paddr == '0));

endmodule

// File: tb/mstlb_top_tb.sv
module mstlb_top_tb;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_all = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_user = 1'b0;
    logic        lk_write = 1'b0;
    logic        fill_valid = 1'b0;
    logic [18:0] fill_vpn = '0;
    logic [18:0] fill_ppn = '0;
    logic        fill_super = 1'b0;
    logic [3:0]  fill_perm = '0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, miss_pending;
    logic [31:0] rsp_paddr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mstlb_top #(.N_ENTRIES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush_all(flush_all),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_user(lk_user), .lk_write(lk_write),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_super(fill_super), .fill_perm(fill_perm),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .miss_pending(miss_pending)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drives one lookup on a falling edge; outputs are read one cycle later
    task automatic lookup(input logic [18:0] vpn, input logic [12:0] off,
                          input logic user, input logic wr);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_vaddr = {vpn, off};
        lk_user  = user;
        lk_write = wr;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic fill(input logic [18:0] vpn, input logic [18:0] ppn,
                        input logic sp, input logic [3:0] perm);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_vpn   = vpn;
        fill_ppn   = ppn;
        fill_super = sp;
        fill_perm  = perm;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic flush();
        @(negedge clk);
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
    endtask

    task automatic expect_hit(input string req, input logic [18:0] vpn,
                              input logic [12:0] off, input logic user, input logic wr,
                              input logic [31:0] pa);
        lookup(vpn, off, user, wr);
        chk(rsp_valid && rsp_hit, req, {rsp_valid, rsp_hit, rsp_miss, rsp_fault}, 4'b1100);
        chk(rsp_paddr == pa, req, rsp_paddr, pa);
    endtask

    task automatic expect_miss(input string req, input logic [18:0] vpn);
        lookup(vpn, 13'h0, 1'b0, 1'b0);
        chk(rsp_valid && rsp_miss && !rsp_hit, req,
            {rsp_valid, rsp_hit, rsp_miss, rsp_fault}, 4'b1010);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!rsp_valid && !miss_pending, "R1 reset", {rsp_valid, miss_pending}, 0);
    endtask

    task automatic t_base_and_miss();
        expect_miss("R6 cold miss", 19'h00123);
        chk(miss_pending, "R6 pending set", miss_pending, 1);
        lookup(19'h00123, 13'h0, 1'b0, 1'b0);
        chk(!rsp_valid, "R6 lookup ignored while pending", rsp_valid, 0);
        fill(19'h00123, 19'h004A5, 1'b0, 4'hF);
        chk(!miss_pending, "R6 pending cleared by fill", miss_pending, 0);
        expect_hit("R3 base translation", 19'h00123, 13'h1ABC, 1'b0, 1'b0,
                   {19'h004A5, 13'h1ABC});
        expect_miss("R3 neighbour base page misses", 19'h00122);
        fill(19'h00122, 19'h00001, 1'b0, 4'hF);
    endtask

    task automatic t_superpage();
        fill(19'h00340, 19'h07771, 1'b1, 4'hF);
        expect_hit("R4 superpage low bits pass", 19'h0034B, 13'h0055, 1'b1, 1'b0,
                   {19'h0777B, 13'h0055});
        expect_hit("R4 superpage top of group", 19'h0034F, 13'h1FFF, 1'b0, 1'b1,
                   {19'h0777F, 13'h1FFF});
        expect_miss("R4 next group misses", 19'h00350);
        fill(19'h00350, 19'h00002, 1'b0, 4'hF);
    endtask

    task automatic t_perm();
        fill(19'h00200, 19'h00AAA, 1'b0, 4'b0001);
        expect_hit("R5 user read allowed", 19'h00200, 13'h10, 1'b1, 1'b0, {19'h00AAA, 13'h10});
        lookup(19'h00200, 13'h10, 1'b1, 1'b1);
        chk(rsp_fault && !rsp_hit && rsp_paddr == 0, "R5 user write faults",
            {rsp_fault, rsp_hit, rsp_paddr}, {1'b1, 1'b0, 32'h0});
        chk(!miss_pending, "R6 fault leaves pending clear", miss_pending, 0);
        lookup(19'h00200, 13'h10, 1'b0, 1'b0);
        chk(rsp_fault && !rsp_hit, "R5 kernel read faults", {rsp_fault, rsp_hit}, 2'b10);
        fill(19'h00201, 19'h00BBB, 1'b0, 4'b1100);
        expect_hit("R5 kernel write allowed", 19'h00201, 13'h0, 1'b0, 1'b1, {19'h00BBB, 13'h0});
        lookup(19'h00201, 13'h0, 1'b1, 1'b0);
        chk(rsp_fault && !rsp_hit, "R5 user read on kernel page faults",
            {rsp_fault, rsp_hit}, 2'b10);
    endtask

    task automatic t_overwrite();
        fill(19'h00123, 19'h00555, 1'b0, 4'hF);
        expect_hit("R7 overwrite returns new page", 19'h00123, 13'h0004, 1'b0, 1'b0,
                   {19'h00555, 13'h0004});
    endtask

    task automatic t_flush();
        flush();
        expect_miss("R1 flush invalidates", 19'h00123);
        flush();
        chk(!miss_pending, "R1 flush clears pending", miss_pending, 0);
        @(negedge clk);
        flush_all  = 1'b1;
        fill_valid = 1'b1;
        fill_vpn   = 19'h00777;
        fill_ppn   = 19'h00001;
        fill_super = 1'b0;
        fill_perm  = 4'hF;
        @(negedge clk);
        flush_all  = 1'b0;
        fill_valid = 1'b0;
        expect_miss("R9 flush beats fill", 19'h00777);
        flush();
    endtask

    task automatic t_lru();
        for (int i = 0; i < N; i++) fill(19'h00010 + 19'(i), 19'h00100 + 19'(i), 1'b0, 4'hF);
        expect_hit("R8 oldest refreshed by hit", 19'h00010, 13'h0, 1'b0, 1'b0, {19'h00100, 13'h0});
        fill(19'h00018, 19'h00108, 1'b0, 4'hF);
        expect_hit("R8 refreshed entry kept", 19'h00010, 13'h0, 1'b0, 1'b0, {19'h00100, 13'h0});
        expect_hit("R8 new entry present", 19'h00018, 13'h0, 1'b0, 1'b0, {19'h00108, 13'h0});
        expect_miss("R8 least recent evicted", 19'h00011);
        flush();
    endtask

    task automatic t_fault_no_touch();
        for (int i = 0; i < N; i++) fill(19'h00020 + 19'(i), 19'h00200 + 19'(i), 1'b0, 4'b0001);
        lookup(19'h00020, 13'h0, 1'b1, 1'b1);
        chk(rsp_fault, "R10 fault on oldest", rsp_fault, 1);
        expect_miss("R10 miss on absent page", 19'h00030);
        fill(19'h00028, 19'h00208, 1'b0, 4'b0001);
        expect_miss("R10 faulted entry still evicted", 19'h00020);
        fill(19'h00029, 19'h00209, 1'b0, 4'b0001);
        expect_hit("R10 second oldest evicted next, recent kept", 19'h00027, 13'h0,
                   1'b1, 1'b0, {19'h00207, 13'h0});
        flush();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_base_and_miss();
        t_superpage();
        t_perm();
        t_overwrite();
        t_flush();
        t_lru();
        t_fault_no_touch();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule